// File: doc/BRIEF.md
# Way-Predicting Four-Way Cache Lookup

This block is the read path of a four-way set-associative cache. Each set keeps a two-bit guess of the way most likely to hold the requested block. That guess steers the data multiplexer as soon as the request is registered. When the guess is right, the block returns the data on the next cycle. When the guess is wrong, the block spends one more cycle on a compare of all four ways. It then returns either the data from the way that really matched, flagged as a slow hit, or a miss.

A requester presents a block address with `req_valid`. The request is taken on any clock edge where `req_ready` is also high. The low bits of the address pick the set and the remaining high bits form the tag. A separate fill port writes a tag and a data word into a chosen way of the addressed set. The fill also points that set's guess at the filled way. Choosing the victim way and talking to the next memory level are done outside the block.

Top module: `wp_lookup`

## Requirements
- R1: After reset every way of every set is invalid and every set predicts way 0. Also after reset, `req_ready` is 1, `resp_valid` is 0, and the first lookup of any address reports a miss.
- R2: The set index is the block address modulo SETS, which is its low log2(SETS) bits. The tag is the remaining high bits. A block filled in one set never produces a hit for an address whose index selects another set, even when the tags are equal.
- R3: When the predicted way of the set is valid and its tag matches, the response comes in the cycle after the request is accepted. In that cycle `resp_valid`=1, `hit`=1, `slow_hit`=0, `miss`=0, `resp_way` is the way number in binary (0 to 3), and `resp_data` is that way's word. In a response cycle exactly one of fast hit, slow hit or miss is signalled, and when `resp_valid`=0 all three are low.
- R4: When the predicted way does not match but another valid way does, the response comes two cycles after acceptance. In that cycle `resp_valid`=1, `hit`=1, `slow_hit`=1, and `resp_way`/`resp_data` come from the matching way.
- R5: After a slow hit, the set predicts the way that hit. A repeat of the same lookup is then a fast hit.
- R6: When no valid way matches, the response comes two cycles after acceptance with `resp_valid`=1, `miss`=1 and `hit`=0. The set's prediction is left unchanged.
- R7: A fill marks the chosen way of the addressed set valid, stores the tag and the data, and makes the filled way the set's prediction. The predictions of other sets are not changed. If a fill and a slow-hit update target the same set in the same cycle, the fill's way wins.
- R8: In the cycle after accepting a request whose predicted way does not match, `req_ready` is 0. A request presented in that cycle is not taken and produces no response.
- R9: Lookups that each hit their predicted way can be accepted on consecutive cycles. Each one returns its own response in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | ADDR_W | Block address of the lookup |
| req_ready | output | 1 | Request can be taken this cycle |
| resp_valid | output | 1 | Response present this cycle |
| hit | output | 1 | Lookup hit (fast or slow) |
| slow_hit | output | 1 | Hit found only after a wrong prediction |
| miss | output | 1 | No way matched |
| resp_way | output | 2 | Way number that supplied the data |
| resp_data | output | DATA_W | Word from the hitting way |
| fill_valid | input | 1 | Write one way this cycle |
| fill_addr | input | ADDR_W | Block address being filled |
| fill_way | input | 2 | Way to write |
| fill_data | input | DATA_W | Word to store |

## Verification
A corrupted prediction does not change which data is returned. It shows only as timing: a lookup that should take one cycle answers in two with `slow_hit` set, and `req_ready` drops during the extra cycle. The bench therefore checks the response cycle, not only the data. A stale or missing valid bit or tag shows up as a wrong miss or a wrong hit two cycles after the request. Update and no-update cases are exposed on the very next lookup of the same address: that lookup returns fast if the set kept or learned the right way, and slow if it did not.

// File: rtl/wp_pkg.sv
package wp_pkg;

    localparam int NUM_WAYS = 4;
    localparam int WAY_W    = 2;

    typedef logic [WAY_W-1:0]    way_t;
    typedef logic [NUM_WAYS-1:0] way_vec_t;

    typedef enum logic [1:0] {
        RSP_IDLE,
        RSP_FAST,
        RSP_SLOW,
        RSP_MISS
    } rsp_kind_t;

    // Lowest-numbered set bit of a way vector, 0 when empty.
    function automatic way_t lowest_way(way_vec_t vec);
        way_t idx;
        idx = '0;
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (vec[i]) idx = way_t'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/wp_tag_store.sv
module wp_tag_store
    import wp_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int TAG_W = 7,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_set,
    input  way_t             fill_way,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [IDX_W-1:0] rd_set,
    input  logic [TAG_W-1:0] rd_tag,
    output way_vec_t         match_vec
);

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic [SETS-1:0]  vld_q;
        logic [TAG_W-1:0] tag_q [SETS];
        logic             wr_here;

        assign wr_here = fill_en && (fill_way == way_t'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= '0;
            end else if (wr_here) begin
                vld_q[fill_set] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_here) begin
                tag_q[fill_set] <= fill_tag;
            end
        end

        assign match_vec[w] = vld_q[rd_set] && (tag_q[rd_set] == rd_tag);
    end

endmodule

// File: rtl/wp_data_store.sv
module wp_data_store
    import wp_pkg::*;
#(
    parameter int SETS   = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_set,
    input  way_t              fill_way,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [IDX_W-1:0]  rd_set,
    input  way_t              rd_way,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] way_word [NUM_WAYS];

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic [DATA_W-1:0] mem_q [SETS];

        always_ff @(posedge clk) begin
            if (fill_en && (fill_way == way_t'(w))) begin
                mem_q[fill_set] <= fill_data;
            end
        end

        assign way_word[w] = mem_q[rd_set];
    end

    assign rd_data = way_word[rd_way];

endmodule

// File: rtl/wp_predictor.sv
module wp_predictor
    import wp_pkg::*;
#(
    parameter int SETS = 8,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        fill_en,
    input  logic [IDX_W-1:0]            fill_set,
    input  way_t                        fill_way,
    input  logic                        upd_en,
    input  logic [IDX_W-1:0]            upd_set,
    input  way_t                        upd_way,
    output logic [SETS-1:0][WAY_W-1:0]  pred_vec
);

    logic [SETS-1:0][WAY_W-1:0] pred_q;

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic fill_hit;
        logic upd_hit;

        assign fill_hit = fill_en && (fill_set == IDX_W'(s));
        assign upd_hit  = upd_en  && (upd_set  == IDX_W'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                pred_q[s] <= '0;
            end else if (fill_hit) begin
                pred_q[s] <= fill_way;
            end else if (upd_hit) begin
                pred_q[s] <= upd_way;
            end
        end
    end

    assign pred_vec = pred_q;

    // R1: leaving reset, every set points at way 0.
    assert_reset_pred_R1: assert property (@(posedge clk)
        $fell(rst) |-> (pred_q == '0))
        else $error("prediction not cleared by reset");

endmodule

// File: rtl/wp_lookup.sv
module wp_lookup
    import wp_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int SETS   = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              hit,
    output logic              slow_hit,
    output logic              miss,
    output logic [1:0]        resp_way,
    output logic [DATA_W-1:0] resp_data,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [1:0]        fill_way,
    input  logic [DATA_W-1:0] fill_data
);

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef logic [IDX_W-1:0] set_t;
    typedef logic [TAG_W-1:0] tag_t;

    // First stage: request registered, predicted way examined.
    logic s1_valid;
    set_t s1_set;
    tag_t s1_tag;
    // Second stage: full compare after a wrong guess.
    logic s2_valid;
    set_t s2_set;
    tag_t s2_tag;

    set_t fill_set;
    tag_t fill_tag;
    set_t rd_set;
    tag_t rd_tag;
    way_t rd_way;
    way_t pred_s1;
    way_t hit_way;
    way_vec_t match_vec;
    logic fast_match;
    logic any_match;
    logic accept;
    logic [SETS-1:0][WAY_W-1:0] pred_vec;
    rsp_kind_t kind;

    assign fill_set = fill_addr[IDX_W-1:0];
    assign fill_tag = fill_addr[ADDR_W-1:IDX_W];

    assign req_ready = !(s1_valid && !fast_match);
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s2_valid <= 1'b0;
        end else begin
            s1_valid <= accept;
            s2_valid <= s1_valid && !fast_match;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            s1_set <= req_addr[IDX_W-1:0];
            s1_tag <= req_addr[ADDR_W-1:IDX_W];
        end
        if (s1_valid) begin
            s2_set <= s1_set;
            s2_tag <= s1_tag;
        end
    end

    // The two stages never hold work at once, so one compare port serves both.
    assign rd_set = s2_valid ? s2_set : s1_set;
    assign rd_tag = s2_valid ? s2_tag : s1_tag;

    assign pred_s1    = pred_vec[s1_set];
    assign fast_match = match_vec[pred_s1];
    assign any_match  = |match_vec;
    assign hit_way    = lowest_way(match_vec);
    assign rd_way     = s2_valid ? hit_way : pred_s1;

    always_comb begin
        if (s2_valid) begin
            kind = any_match ? RSP_SLOW : RSP_MISS;
        end else if (s1_valid && fast_match) begin
            kind = RSP_FAST;
        end else begin
            kind = RSP_IDLE;
        end
    end

    assign resp_valid = (kind != RSP_IDLE);
    assign hit        = (kind == RSP_FAST) || (kind == RSP_SLOW);
    assign slow_hit   = (kind == RSP_SLOW);
    assign miss       = (kind == RSP_MISS);
    assign resp_way   = rd_way;

    wp_tag_store #(
        .SETS  (SETS),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk       (clk),
        .rst       (rst),
        .fill_en   (fill_valid),
        .fill_set  (fill_set),
        .fill_way  (fill_way),
        .fill_tag  (fill_tag),
        .rd_set    (rd_set),
        .rd_tag    (rd_tag),
        .match_vec (match_vec)
    );

    wp_data_store #(
        .SETS   (SETS),
        .DATA_W (DATA_W)
    ) u_data (
        .clk       (clk),
        .fill_en   (fill_valid),
        .fill_set  (fill_set),
        .fill_way  (fill_way),
        .fill_data (fill_data),
        .rd_set    (rd_set),
        .rd_way    (rd_way),
        .rd_data   (resp_data)
    );

    wp_predictor #(
        .SETS (SETS)
    ) u_pred (
        .clk      (clk),
        .rst      (rst),
        .fill_en  (fill_valid),
        .fill_set (fill_set),
        .fill_way (fill_way),
        .upd_en   (slow_hit),
        .upd_set  (s2_set),
        .upd_way  (hit_way),
        .pred_vec (pred_vec)
    );

    // R3: a response carries exactly one outcome; no outcome flags when idle.
    assert_one_kind_R3: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> ($countones({hit && !slow_hit, slow_hit, miss}) == 1))
        else $error("response outcome not unique");

    assert_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !resp_valid |-> (!hit && !slow_hit && !miss))
        else $error("outcome flag without response");

    // R8: a stalled cycle is always followed by the slow outcome.
    assert_stall_R8: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> (resp_valid && (slow_hit || miss)))
        else $error("stall not followed by slow response");

    // R5: the set learns the way that produced a slow hit.
    assert_learn_R5: assert property (@(posedge clk) disable iff (rst)
        (slow_hit && !(fill_valid && (fill_set == s2_set)))
        |=> (pred_vec[$past(s2_set)] == $past(resp_way)))
        else $error("prediction not updated after slow hit");

    // R6: a miss leaves the set's prediction alone.
    assert_keep_R6: assert property (@(posedge clk) disable iff (rst)
        (miss && !(fill_valid && (fill_set == s2_set)))
        |=> (pred_vec[$past(s2_set)] == $past(pred_vec[s2_set])))
        else $error("prediction changed on miss");

endmodule

// File: tb/wp_lookup_tb.sv
module wp_lookup_tb;

    localparam int ADDR_W = 10;
    localparam int SETS   = 8;
    localparam int DATA_W = 32;

    localparam int K_FAST = 0;
    localparam int K_SLOW = 1;
    localparam int K_MISS = 2;
    localparam int K_NONE = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready;
    logic              resp_valid;
    logic              hit;
    logic              slow_hit;
    logic              miss;
    logic [1:0]        resp_way;
    logic [DATA_W-1:0] resp_data;
    logic              fill_valid = 1'b0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic [1:0]        fill_way = '0;
    logic [DATA_W-1:0] fill_data = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    wp_lookup #(
        .ADDR_W (ADDR_W),
        .SETS   (SETS),
        .DATA_W (DATA_W)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_ready  (req_ready),
        .resp_valid (resp_valid),
        .hit        (hit),
        .slow_hit   (slow_hit),
        .miss       (miss),
        .resp_way   (resp_way),
        .resp_data  (resp_data),
        .fill_valid (fill_valid),
        .fill_addr  (fill_addr),
        .fill_way   (fill_way),
        .fill_data  (fill_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_fill(input int addr, input int way, input int data);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_addr  = ADDR_W'(addr);
        fill_way   = 2'(way);
        fill_data  = DATA_W'(data);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // Issues one request and classifies the response by the cycle it appears in.
    task automatic lookup(input int addr, output int kind, output int way, output int data);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = ADDR_W'(addr);
        @(negedge clk);
        req_valid = 1'b0;
        kind = K_NONE;
        way  = resp_way;
        data = resp_data;
        if (resp_valid && hit && !slow_hit && !miss) begin
            kind = K_FAST;
        end else if (!resp_valid) begin
            @(negedge clk);
            way  = resp_way;
            data = resp_data;
            if (resp_valid && hit && slow_hit && !miss) kind = K_SLOW;
            else if (resp_valid && miss && !hit) kind = K_MISS;
        end
    endtask

    task automatic expect_lookup(input int addr, input int exp_kind, input int exp_way,
                                 input int exp_data, input string req);
        int k, w, d;
        lookup(addr, k, w, d);
        check(k == exp_kind, req, k, exp_kind);
        if (exp_kind != K_MISS && k == exp_kind) begin
            check(w == exp_way, req, w, exp_way);
            check(d == exp_data, req, d, exp_data);
        end
    endtask

    // Addresses: SETS = 8, so index = addr[2:0], tag = addr[9:3].
    localparam int A_ADDR = 13;   // set 5, tag 1
    localparam int B_ADDR = 21;   // set 5, tag 2
    localparam int M_ADDR = 29;   // set 5, tag 3 (never filled)
    localparam int C_ADDR = 11;   // set 3, tag 1
    localparam int Z_ADDR = 3;    // set 3, tag 0 (never filled)
    localparam int A_DATA = 32'h5A5A_0013;
    localparam int B_DATA = 32'h3C3C_0021;
    localparam int C_DATA = 32'h7E7E_0011;

    task automatic t_reset;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        check(resp_valid == 1'b0, "R1 no response after reset", resp_valid, 0);
        expect_lookup(5, K_MISS, 0, 0, "R1 empty cache misses");
    endtask

    task automatic t_fast_after_fill;
        do_fill(A_ADDR, 2, A_DATA);
        expect_lookup(A_ADDR, K_FAST, 2, A_DATA, "R7 R3 fill then fast hit");
    endtask

    task automatic t_slow_and_learn;
        do_fill(B_ADDR, 0, B_DATA);
        expect_lookup(A_ADDR, K_SLOW, 2, A_DATA, "R4 mispredicted hit");
        expect_lookup(A_ADDR, K_FAST, 2, A_DATA, "R5 learned way 2");
        expect_lookup(B_ADDR, K_SLOW, 0, B_DATA, "R4 mispredicted hit way 0");
        expect_lookup(B_ADDR, K_FAST, 0, B_DATA, "R5 learned way 0");
    endtask

    task automatic t_miss_keeps;
        expect_lookup(M_ADDR, K_MISS, 0, 0, "R6 miss in filled set");
        expect_lookup(B_ADDR, K_FAST, 0, B_DATA, "R6 prediction kept after miss");
    endtask

    task automatic t_index;
        do_fill(C_ADDR, 1, C_DATA);
        expect_lookup(B_ADDR, K_FAST, 0, B_DATA, "R7 other set prediction untouched");
        expect_lookup(C_ADDR, K_FAST, 1, C_DATA, "R2 same tag other set");
        expect_lookup(Z_ADDR, K_MISS, 0, 0, "R2 other tag same set misses");
    endtask

    task automatic t_stall;
        // Set 5 predicts way 0; A lives in way 2.
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = ADDR_W'(A_ADDR);
        @(negedge clk);
        req_addr  = ADDR_W'(C_ADDR);
        check(req_ready == 1'b0, "R8 ready low in extra cycle", req_ready, 0);
        check(resp_valid == 1'b0, "R8 no fast response", resp_valid, 0);
        @(negedge clk);
        req_valid = 1'b0;
        check(resp_valid && slow_hit, "R8 R4 slow response", {resp_valid, slow_hit}, 3);
        check(resp_data == DATA_W'(A_DATA), "R8 slow data", resp_data, A_DATA);
        @(negedge clk);
        check(resp_valid == 1'b0, "R8 held request not taken", resp_valid, 0);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = ADDR_W'(A_ADDR);
        @(negedge clk);
        check(resp_valid && hit && !slow_hit, "R9 first fast", {resp_valid, hit, slow_hit}, 6);
        check(resp_data == DATA_W'(A_DATA), "R9 first data", resp_data, A_DATA);
        check(req_ready == 1'b1, "R9 ready stays high", req_ready, 1);
        req_addr = ADDR_W'(C_ADDR);
        @(negedge clk);
        req_valid = 1'b0;
        check(resp_valid && hit && !slow_hit, "R9 second fast", {resp_valid, hit, slow_hit}, 6);
        check(resp_data == DATA_W'(C_DATA), "R9 second data", resp_data, C_DATA);
        check(resp_way == 2'd1, "R9 second way", resp_way, 1);
        @(negedge clk);
        check(resp_valid == 1'b0, "R9 idle after pair", resp_valid, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fast_after_fill();
        t_slow_and_learn();
        t_miss_keeps();
        t_index();
        t_stall();
        t_back_to_back();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule